// File: doc/BRIEF.md
# Mailbox-Commanded I2C Bus Master

This block is an I2C bus master that software drives through six 16-bit registers. Software first places up to two outgoing bytes in a transmit-data mailbox. It then writes a command word that carries four things: the 7-bit target address, the transfer direction, a byte count of one or two, and a flag that keeps the bus after the command. The block then performs the whole bus sequence. It generates START, or a repeated START if the bus was kept by the previous command. It shifts out the address byte, moves the data bytes with acknowledge handling, and ends with STOP unless told to keep the bus. Bytes received on a read are placed in a receive-data mailbox.

Completion and failure are reported through three sticky event flags. Software clears a flag by writing a 1 to its bit. Each flag can be enabled onto a single interrupt line. Transfers longer than two bytes are built by chaining commands, with every command except the last keeping the bus. The bus lines are modelled as open-drain: the block only ever pulls SCL or SDA low or releases it. The SCL rate comes from a fixed divider of the system clock.

Top module: `i2cmb_master`

## Requirements
- R1: Register indices are 0 event status, 1 event enable, 2 transmit data, 3 command, 4 receive data, 5 accepted-command readback (index 3 also reads the accepted command). After reset, every register reads 0, both bus lines are released and the interrupt is low.
- R2: A command takes effect only when bits 15:14 equal binary 10. Bit 10 set means write and clear means read. Bits 7:1 hold the target address. The address byte on the bus is the address followed by an R/W bit that is 0 for write and 1 for read. A command with any other value in bits 15:14 starts nothing and is not recorded.
- R3: A write sends bits 7:0 of the transmit mailbox first, then bits 15:8 when bit 11 of the command is set. Every byte goes MSB first.
- R4: A read places the first received byte in bits 7:0 of the receive mailbox and the second in bits 15:8. A one-byte read leaves bits 15:8 at 0.
- R5: Status bit 13 is error, bit 14 is write done and bit 15 is read done. The flags are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: With command bit 13 clear, the transfer ends in STOP. With bit 13 set, SCL stays low with no STOP, and the next command begins with a repeated START.
- R7: A NACK on the address byte, or on any written data byte, ends the command. The error flag is set, STOP is sent, no further byte is sent, and no done flag is set.
- R8: On a read, the master ACKs every received byte except the last byte of the command, which it NACKs.
- R9: Outside START and STOP, SDA changes only while SCL is low. The SCL period is 4*QDIV system clocks.
- R10: The interrupt is high exactly when some status bit and its matching enable bit (bits 15:13 of index 1) are both set.
- R11: A command written while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_drive_low | output | 1 | Pull SCL low when high, release when low |
| sda_drive_low | output | 1 | Pull SDA low when high, release when low |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
A wrong sequencer state shows up on the bus within one SCL quarter period. Such an error appears as an extra or missing START or STOP, a shifted byte, or the wrong acknowledge level, and a target model sees it as a wrong address, wrong data, or a wrong count of conditions. A fault in the event logic or the mailboxes shows up at the register port as soon as the command completes, through the status word, the receive-data value, or the interrupt level. Corner cases are driven directly: address NACK, data NACK, the kept bus followed by a repeated START, commands issued while busy, and commands that are not native.

// File: rtl/i2cmb_pkg.sv
package i2cmb_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ENABLE  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_TXDATA  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CMD     = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RXDATA  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CMDECHO = 3'd5;

  localparam int CB_DIR  = 10;
  localparam int CB_TWO  = 11;
  localparam int CB_HOLD = 13;
  localparam logic [1:0] CMD_KIND_NATIVE = 2'b10;

  // status flags occupy bits 15:13, stored as {rx_done, tx_done, error}
  localparam int FLAG_LSB = 13;
  localparam int NFLAGS   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_STOP,
    ST_HOLD
  } eng_state_e;

  typedef struct packed {
    logic       wr;
    logic       two;
    logic       hold;
    logic [6:0] addr;
  } cmd_t;
endpackage

// File: rtl/i2cmb_tick.sv
module i2cmb_tick #(
  parameter int QDIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (QDIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9
    end
  endgenerate
endmodule

// File: rtl/i2cmb_regs.sv
module i2cmb_regs
  import i2cmb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic               busy,
  input  logic               evt_tx,
  input  logic               evt_rx,
  input  logic               evt_err,
  input  logic [REG_W-1:0]   rxdata,
  output logic               start,
  output cmd_t               cmd,
  output logic [REG_W-1:0]   txdata,
  output logic               irq
);
  logic [NFLAGS-1:0] stat_q, stat_d, en_q, en_d;
  logic [REG_W-1:0]  tx_q, tx_d, rx_q, rx_d, echo_q, echo_d;
  logic wr_stat, wr_en, wr_tx, wr_cmd;

  always_comb begin
    wr_stat = cs && we && (idx == IDX_STATUS);
    wr_en   = cs && we && (idx == IDX_ENABLE);
    wr_tx   = cs && we && (idx == IDX_TXDATA);
    wr_cmd  = cs && we && (idx == IDX_CMD);
    start   = wr_cmd && (wdata[REG_W-1 -: 2] == CMD_KIND_NATIVE) && !busy;

    cmd.wr   = wdata[CB_DIR];
    cmd.two  = wdata[CB_TWO];
    cmd.hold = wdata[CB_HOLD];
    cmd.addr = wdata[7:1];

    stat_d = (stat_q & ~(wr_stat ? wdata[FLAG_LSB +: NFLAGS] : '0))
           | {evt_rx, evt_tx, evt_err};
    en_d   = wr_en  ? wdata[FLAG_LSB +: NFLAGS] : en_q;
    tx_d   = wr_tx  ? wdata  : tx_q;
    rx_d   = evt_rx ? rxdata : rx_q;
    echo_d = start  ? wdata  : echo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      echo_q <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      echo_q <= echo_d;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_STATUS:  rdata = {stat_q, {FLAG_LSB{1'b0}}};
      IDX_ENABLE:  rdata = {en_q, {FLAG_LSB{1'b0}}};
      IDX_TXDATA:  rdata = tx_q;
      IDX_CMD:     rdata = echo_q;
      IDX_RXDATA:  rdata = rx_q;
      IDX_CMDECHO: rdata = echo_q;
      default:     rdata = '0;
    endcase
  end

  assign txdata = tx_q;
  assign irq    = |(stat_q & en_q);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> stat_q[0]); // R5
  AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[REG_W-1] && !evt_rx) |=> !stat_q[2]); // R5
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy) |=> $stable(echo_q)); // R11
endmodule

// File: rtl/i2cmb_engine.sv
module i2cmb_engine
  import i2cmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  cmd_t             cmd_in,
  input  logic [REG_W-1:0] txdata,
  input  logic             sda_in,
  output logic             busy,
  output logic             evt_tx,
  output logic             evt_rx,
  output logic             evt_err,
  output logic [REG_W-1:0] rxdata,
  output logic             scl_low,
  output logic             sda_low
);
  eng_state_e        st_q, st_d;
  logic [1:0]        q_q, q_d;
  logic [3:0]        bit_q, bit_d;
  logic [1:0]        stg_q, stg_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [REG_W-1:0]  rx_q, rx_d, tx_q, tx_d;
  cmd_t              cmd_q, cmd_d;
  logic              fromh_q, fromh_d, nack_q, nack_d, err_q, err_d;
  logic [1:0]        sync_q;
  logic              scl_q, sda_q, bitph_q;
  logic              scl_d, sda_d;
  logic [1:0]        last_stg;
  logic              rx_byte, last_byte, sda_s;

  assign last_stg  = cmd_q.two ? 2'd2 : 2'd1;
  assign rx_byte   = !cmd_q.wr && (stg_q != 2'd0);
  assign last_byte = (stg_q == last_stg);
  assign sda_s     = sync_q[1];

  // two-stage synchronizer for the sensed SDA level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], sda_in};
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    q_d     = q_q;
    bit_d   = bit_q;
    stg_d   = stg_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    cmd_d   = cmd_q;
    fromh_d = fromh_q;
    nack_d  = nack_q;
    err_d   = err_q;
    evt_tx  = 1'b0;
    evt_rx  = 1'b0;
    evt_err = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_HOLD: begin
        if (start) begin
          st_d    = ST_START;
          q_d     = 2'd0;
          cmd_d   = cmd_in;
          tx_d    = txdata;
          err_d   = 1'b0;
          fromh_d = (st_q == ST_HOLD);
        end
      end
      ST_START: begin
        if (tick) begin
          q_d = q_q + 2'd1;
          if (q_q == 2'd3) begin
            st_d  = ST_BIT;
            bit_d = 4'd0;
            stg_d = 2'd0;
            sh_d  = {cmd_q.addr, !cmd_q.wr};
            rx_d  = '0;
          end
        end
      end
      ST_BIT: begin
        if (tick) begin
          q_d = q_q + 2'd1;
          if (q_q == 2'd2) begin
            if (bit_q == 4'd8)  nack_d = sda_s;
            else if (rx_byte)   sh_d   = {sh_q[BYTE_W-2:0], sda_s};
          end
          if (q_q == 2'd3) begin
            if (bit_q != 4'd8) begin
              bit_d = bit_q + 4'd1;
              if (bit_q == 4'd7 && rx_byte) begin
                if (stg_q == 2'd1) rx_d[7:0]  = sh_q;
                else               rx_d[15:8] = sh_q;
              end
            end else if (!rx_byte && nack_q) begin
              st_d  = ST_STOP;
              err_d = 1'b1;
            end else if (last_byte) begin
              if (cmd_q.hold) begin
                st_d   = ST_HOLD;
                evt_tx = cmd_q.wr;
                evt_rx = !cmd_q.wr;
              end else begin
                st_d = ST_STOP;
              end
            end else begin
              stg_d = stg_q + 2'd1;
              bit_d = 4'd0;
              sh_d  = (stg_q == 2'd0) ? tx_q[7:0] : tx_q[15:8];
            end
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          q_d = q_q + 2'd1;
          if (q_q == 2'd3) begin
            st_d    = ST_IDLE;
            evt_err = err_q;
            evt_tx  = !err_q && cmd_q.wr;
            evt_rx  = !err_q && !cmd_q.wr;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // line drive decode from the current state
  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    unique case (st_q)
      ST_START: begin
        scl_d = (q_q == 2'd3) || (q_q == 2'd0 && fromh_q);
        sda_d = q_q[1];
      end
      ST_BIT: begin
        scl_d = (q_q == 2'd0) || (q_q == 2'd3);
        if (bit_q == 4'd8) sda_d = rx_byte && !last_byte;
        else               sda_d = !rx_byte && !sh_q[3'd7 - bit_q[2:0]];
      end
      ST_STOP: begin
        scl_d = (q_q == 2'd0);
        sda_d = !q_q[1];
      end
      ST_HOLD: scl_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      q_q     <= '0;
      bit_q   <= '0;
      stg_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      cmd_q   <= '0;
      fromh_q <= 1'b0;
      nack_q  <= 1'b0;
      err_q   <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      bitph_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      q_q     <= q_d;
      bit_q   <= bit_d;
      stg_q   <= stg_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      cmd_q   <= cmd_d;
      fromh_q <= fromh_d;
      nack_q  <= nack_d;
      err_q   <= err_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      bitph_q <= (st_q == ST_BIT);
    end
  end

  assign busy    = (st_q != ST_IDLE) && (st_q != ST_HOLD);
  assign rxdata  = rx_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bitph_q && $past(bitph_q) && !scl_q && $past(!scl_q)) |-> $stable(sda_q)); // R9
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && $past(st_q == ST_HOLD)) |-> scl_q); // R6
  AST_NACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BIT && tick && q_q == 2'd3 && bit_q == 4'd8 && !rx_byte && nack_q)
      |=> (st_q == ST_STOP)); // R7
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R11
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_tx, evt_rx, evt_err})); // R5
endmodule

// File: rtl/i2cmb_master.sv
module i2cmb_master
  import i2cmb_pkg::*;
#(
  parameter int QDIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_cs,
  input  logic             reg_we,
  input  logic [2:0]       reg_idx,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             irq,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  input  logic             sda_in
);
  logic [1:0]       rs_q;
  logic             rst_sn;
  logic             tick, start, busy, evt_tx, evt_rx, evt_err;
  cmd_t             cmd;
  logic [REG_W-1:0] txdata, rxdata;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  i2cmb_tick #(.QDIV(QDIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sn),
    .tick  (tick)
  );

  i2cmb_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .cs      (reg_cs),
    .we      (reg_we),
    .idx     (reg_idx),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .busy    (busy),
    .evt_tx  (evt_tx),
    .evt_rx  (evt_rx),
    .evt_err (evt_err),
    .rxdata  (rxdata),
    .start   (start),
    .cmd     (cmd),
    .txdata  (txdata),
    .irq     (irq)
  );

  i2cmb_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_sn),
    .tick    (tick),
    .start   (start),
    .cmd_in  (cmd),
    .txdata  (txdata),
    .sda_in  (sda_in),
    .busy    (busy),
    .evt_tx  (evt_tx),
    .evt_rx  (evt_rx),
    .evt_err (evt_err),
    .rxdata  (rxdata),
    .scl_low (scl_drive_low),
    .sda_low (sda_drive_low)
  );
endmodule

// File: tb/i2cmb_master_bench.sv
`timescale 1ns/1ps
module i2cmb_master_bench;
  localparam int QDIV = 5;
  localparam logic [6:0] TADDR = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_cs = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_idx = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic irq, scl_drive_low, sda_drive_low;
  logic s_drive = 1'b0;
  wire scl_line = ~scl_drive_low;
  wire sda_line = ~(sda_drive_low | s_drive);

  always #2.5 clk = ~clk;

  i2cmb_master #(.QDIV(QDIV)) u_i2cmb_master (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .sda_in(sda_line)
  );

  int checks = 0, fails = 0;
  int cyc = 0;

  // ---------------- target model ----------------
  logic clr = 1'b0;
  int   nack_at = -1;
  int   starts, stops, addr_n, wr_n, mack_n, tx_cnt;
  logic [7:0] addr_log, rxb, txb;
  logic [7:0] wr_log [0:7];
  logic       mack_log [0:7];
  int   mode, bitn;
  logic in_ack, is_addr, acked, mack, prev_scl, prev_sda;
  int   last_rise, last_period;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n || clr) begin
      starts = 0; stops = 0; addr_n = 0; wr_n = 0; mack_n = 0; tx_cnt = 0;
      mode = 0; bitn = 0; in_ack = 0; is_addr = 0; acked = 0; s_drive = 0;
      addr_log = 8'h00;
      if (!rst_n) begin last_rise = 0; last_period = 0; end
    end else if (prev_scl && scl_line && prev_sda && !sda_line) begin
      starts = starts + 1;
      mode = 1; bitn = 0; in_ack = 0; is_addr = 1; s_drive = 0;
    end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
      stops = stops + 1;
      mode = 0; s_drive = 0;
    end else if (!prev_scl && scl_line) begin
      last_period = cyc - last_rise;
      last_rise = cyc;
      if (mode == 1 && bitn < 8) begin
        rxb = {rxb[6:0], sda_line}; bitn = bitn + 1;
      end else if (mode == 2 && bitn < 8) begin
        bitn = bitn + 1;
      end else if (mode == 2 && bitn == 8) begin
        mack = sda_line;
        if (mack_n < 8) mack_log[mack_n] = mack;
        mack_n = mack_n + 1; bitn = 9;
      end
    end else if (prev_scl && !scl_line) begin
      if (mode == 1) begin
        if (bitn == 8 && !in_ack) begin
          in_ack = 1;
          if (is_addr) begin
            addr_log = rxb; addr_n = addr_n + 1;
            acked = (rxb[7:1] == TADDR);
          end else begin
            if (wr_n < 8) wr_log[wr_n] = rxb;
            acked = (wr_n != nack_at);
            wr_n = wr_n + 1;
          end
          s_drive = acked;
        end else if (in_ack) begin
          in_ack = 0; s_drive = 0; bitn = 0;
          if (!acked) mode = 0;
          else if (is_addr && rxb[0]) begin
            mode = 2; txb = 8'hA0 + 8'(tx_cnt); tx_cnt = tx_cnt + 1;
            s_drive = ~txb[7];
          end
          is_addr = 0;
        end
      end else if (mode == 2) begin
        if (bitn < 8) s_drive = ~txb[7 - bitn];
        else if (bitn == 8) s_drive = 0;
        else if (!mack) begin
          txb = 8'hA0 + 8'(tx_cnt); tx_cnt = tx_cnt + 1;
          bitn = 0; s_drive = ~txb[7];
        end else begin
          mode = 0; s_drive = 0;
        end
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] i, input logic [15:0] d);
    @(negedge clk); reg_cs = 1; reg_we = 1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_cs = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] i, output logic [15:0] v);
    @(negedge clk); reg_idx = i; reg_cs = 1; reg_we = 0;
    #1 v = reg_rdata; reg_cs = 0;
  endtask

  task automatic wait_flags(input logic [15:0] mask);
    logic [15:0] v;
    for (int n = 0; n < 20000; n++) begin
      reg_rd(3'd0, v);
      if ((v & mask) != 0) break;
    end
  endtask

  task automatic slave_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); #1 clr = 0;
  endtask

  task automatic clr_status();
    reg_wr(3'd0, 16'hE000);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 6; i++) begin
      reg_rd(3'(i), v);
      check("R1 reset register value", v, 16'h0);
    end
    check("R1 lines released after reset", {scl_drive_low, sda_drive_low}, 2'b00);
    check("R1 irq low after reset", irq, 1'b0);
  endtask

  task automatic t_write2();
    logic [15:0] v;
    slave_clear();
    reg_wr(3'd2, 16'hBEEF);
    reg_wr(3'd3, 16'h8CA0);
    wait_flags(16'hE000);
    reg_rd(3'd0, v);
    check("R5 write done flag only", v, 16'h4000);
    check("R2 address byte write", addr_log, 8'hA0);
    check("R3 first byte from bits 7:0", wr_log[0], 8'hEF);
    check("R3 second byte from bits 15:8", wr_log[1], 8'hBE);
    check("R3 two data bytes", wr_n, 2);
    check("R6 one START", starts, 1);
    check("R6 STOP ends transfer", stops, 1);
    check("R9 SCL period", last_period, 4 * QDIV);
    check("R10 irq masked when disabled", irq, 1'b0);
    reg_wr(3'd1, 16'h4000);
    #1 check("R10 irq raised when enabled", irq, 1'b1);
    reg_wr(3'd0, 16'h2000);
    reg_rd(3'd0, v);
    check("R5 clearing other bit keeps flag", v, 16'h4000);
    reg_wr(3'd0, 16'h4000);
    reg_rd(3'd0, v);
    check("R5 write one clears flag", v, 16'h0000);
    #1 check("R10 irq drops after clear", irq, 1'b0);
    reg_wr(3'd1, 16'h0000);
  endtask

  task automatic t_read2();
    logic [15:0] v;
    slave_clear();
    reg_wr(3'd3, 16'h88A0);
    wait_flags(16'hE000);
    reg_rd(3'd0, v);
    check("R5 read done flag only", v, 16'h8000);
    check("R2 address byte read", addr_log, 8'hA1);
    reg_rd(3'd4, v);
    check("R4 two-byte read placement", v, 16'hA1A0);
    check("R8 first byte ACKed", mack_log[0], 1'b0);
    check("R8 last byte NACKed", mack_log[1], 1'b1);
    check("R8 two acknowledge slots", mack_n, 2);
    clr_status();
  endtask

  task automatic t_read1();
    logic [15:0] v;
    slave_clear();
    reg_wr(3'd3, 16'h80A0);
    wait_flags(16'hE000);
    reg_rd(3'd4, v);
    check("R4 one-byte read upper zero", v, 16'h00A0);
    check("R8 single byte NACKed", mack_log[0], 1'b1);
    check("R6 STOP after read", stops, 1);
    clr_status();
  endtask

  task automatic t_nack_addr();
    logic [15:0] v;
    slave_clear();
    reg_wr(3'd2, 16'h1111);
    reg_wr(3'd3, 16'h8C66);
    wait_flags(16'hE000);
    reg_rd(3'd0, v);
    check("R7 address NACK sets error only", v, 16'h2000);
    check("R7 no data after address NACK", wr_n, 0);
    check("R7 STOP after address NACK", stops, 1);
    reg_wr(3'd1, 16'h2000);
    #1 check("R10 irq on enabled error", irq, 1'b1);
    reg_wr(3'd1, 16'h0000);
    clr_status();
  endtask

  task automatic t_nack_data();
    logic [15:0] v;
    slave_clear();
    nack_at = 0;
    reg_wr(3'd2, 16'h5A3C);
    reg_wr(3'd3, 16'h8CA0);
    wait_flags(16'hE000);
    reg_rd(3'd0, v);
    check("R7 data NACK sets error only", v, 16'h2000);
    check("R7 second byte not sent", wr_n, 1);
    check("R7 STOP after data NACK", stops, 1);
    nack_at = -1;
    clr_status();
  endtask

  task automatic t_hold();
    logic [15:0] v;
    slave_clear();
    reg_wr(3'd2, 16'h0055);
    reg_wr(3'd3, 16'hA4A0);
    wait_flags(16'hE000);
    reg_rd(3'd0, v);
    check("R6 held write completes", v, 16'h4000);
    repeat (40) @(negedge clk);
    check("R6 SCL held low", scl_drive_low, 1'b1);
    check("R6 no STOP while held", stops, 0);
    check("R3 held write byte", wr_log[0], 8'h55);
    clr_status();
    reg_wr(3'd3, 16'h80A0);
    wait_flags(16'hE000);
    check("R6 repeated START counted", starts, 2);
    check("R6 single STOP after chain", stops, 1);
    reg_rd(3'd4, v);
    check("R4 read after repeated START", v, 16'h00A0);
    check("R6 bus released at end", scl_drive_low, 1'b0);
    clr_status();
  endtask

  task automatic t_busy();
    logic [15:0] v;
    slave_clear();
    reg_wr(3'd2, 16'h1234);
    reg_wr(3'd3, 16'h8CA0);
    reg_wr(3'd3, 16'h8C66);
    wait_flags(16'hE000);
    repeat (200) @(negedge clk);
    reg_rd(3'd0, v);
    check("R11 busy command ignored no error", v, 16'h4000);
    check("R11 only one address phase", addr_n, 1);
    check("R11 one START", starts, 1);
    reg_rd(3'd3, v);
    check("R11 readback keeps first command", v, 16'h8CA0);
    check("R3 bytes of first command", {wr_log[1], wr_log[0]}, 16'h1234);
    clr_status();
  endtask

  task automatic t_nonnative();
    logic [15:0] v;
    slave_clear();
    reg_wr(3'd3, 16'h4CA0);
    repeat (200) @(negedge clk);
    check("R2 non-native starts nothing", starts, 0);
    check("R2 bus stays released", {scl_drive_low, sda_drive_low}, 2'b00);
    reg_rd(3'd0, v);
    check("R2 no status from non-native", v, 16'h0000);
    reg_rd(3'd5, v);
    check("R2 non-native not recorded", v, 16'h8CA0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    fails = fails + 1;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write2();
    t_read2();
    t_read1();
    t_nack_addr();
    t_nack_data();
    t_hold();
    t_busy();
    t_nonnative();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule